// File: doc/BRIEF.md
# Burst Register-Access SPI Slave

This block lets a host microcontroller read and write a bank of thirty-two 8-bit registers over a byte-oriented SPI link. The link is live only while an active-low configuration select is held low. The first byte after the select falls is a command byte. Its two top bits give the number of registers to access, the next five bits give the first register, and the lowest bit selects read or write. The data bytes that follow go to, or come from, successive registers. The address steps by one after each data byte and wraps at the top of the bank.

The SPI pins are sampled by the block's own clock through synchronizers, and the serial clock edges are found from the synchronized level. The timing follows CPOL=0, CPHA=1. The slave changes its serial output after a rising serial-clock edge, and the host samples it on the falling edge. The slave samples MOSI on the falling edge too. The serial output is sent MSB first.

The output drive is handed to the pad as a data bit and an enable, so the line floats while the block is deselected. A parallel read port lets the surrounding logic see any register at any time.

Top module: `spi_burst_regs`

## Requirements
- R1: While `cfgSelN` is high, `misoOe` is 0 (line released). While it is low, `misoOe` is 1 and `miso` reads 0 until read data is shifted out.
- R2: The first 8 bits after `cfgSelN` falls form the command byte, sent MSB first. Bits 7:6 are the burst code, bits 5:1 are the start address, and bit 0 is 1 for a read and 0 for a write. A read leaves every register unchanged.
- R3: The burst code sets the number of data bytes accessed: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R4: On a write, each complete data byte is stored into the current register. The address then advances by one, modulo 32, so the bytes of a burst land in consecutive registers and wrap from 31 to 0.
- R5: On a read, each data byte shifted out on `miso` (MSB first, sampled by the host on falling `sclk`) is the content of the current register. Successive bytes come from successive registers, modulo 32.
- R6: Data bytes beyond the burst length are ignored. Writes change nothing, and reads return 0x00 until the select rises and falls again.
- R7: If `cfgSelN` rises before a byte is complete, that partial byte is discarded. Bytes already completed in the same burst stay committed.
- R8: `rdData` always shows the register selected by `rdAddr`.
- R9: After reset, every register holds 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the SPI pins |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgSelN | input | 1 | Active-low configuration select |
| sclk | input | 1 | Serial clock from the host, idle low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| misoOe | output | 1 | Output enable for the `miso` pad |
| rdAddr | input | 5 | Parallel read port address |
| rdData | output | 8 | Parallel read port data |

## Verification
On every cycle, the assertions check the following:
- a stored byte lands at the address that was current when it was committed;
- the address steps by exactly one with wrap;
- a fresh burst count is a power of two from 1 to 8, and the address never advances with the count exhausted;
- once a burst is used up, the block stays in its ignore state.

Only the bench scenarios can show the serial-level behaviour: the command bits are decoded in the right order, read bytes come out MSB first in the right half-period, extra bytes read as zero, and an abort mid-byte leaves the target register intact. The bench shows these by sweeping every burst code across start addresses that include the wrap, and comparing a bench-side model against both the parallel read port and the serial read data.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int BYTE_W  = 8;
  localparam int BURST_W = 2;
  localparam int MAX_BURST = 1 << ((1 << BURST_W) - 1);
  localparam int CNT_W = $clog2(MAX_BURST + 1);

  typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_DONE} phase_t;

  typedef struct packed {
    logic flush;
    logic shiftTx;
    logic shiftRx;
    logic loadTx;
    logic clearTx;
    logic addrLoad;
    logic addrInc;
    logic commit;
  } strobe_t;
endpackage

// File: rtl/spi_burst_sync.sv
module spi_burst_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= RST_VAL;
    else       stage[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= RST_VAL;
      else       stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_burst_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               selActive,
  input  logic               sclkS,
  input  logic [BURST_W-1:0] cmdBurst,
  input  logic               cmdRead,
  output strobe_t            st
);
  logic             sclkPrev;
  logic             riseEdge, fallEdge, byteDone;
  logic [2:0]       bitCnt;
  logic [CNT_W-1:0] remaining;
  logic             isRead;
  phase_t           phase;

  assign riseEdge = sclkS & ~sclkPrev;
  assign fallEdge = ~sclkS & sclkPrev;
  assign byteDone = fallEdge && (bitCnt == 3'd7);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkS;
  end

  always_comb begin
    st = '0;
    st.flush = !selActive;
    if (selActive) begin
      st.shiftTx = riseEdge;
      st.shiftRx = fallEdge;
      if (byteDone) begin
        case (phase)
          PH_CMD: begin
            st.addrLoad = 1'b1;
            st.loadTx   = cmdRead;
            st.clearTx  = !cmdRead;
          end
          PH_DATA: begin
            st.addrInc = 1'b1;
            st.commit  = !isRead;
            if (remaining == CNT_W'(1)) st.clearTx = 1'b1;
            else if (isRead)            st.loadTx  = 1'b1;
            else                        st.clearTx = 1'b1;
          end
          default: st.clearTx = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_CMD;
      bitCnt    <= '0;
      remaining <= '0;
      isRead    <= 1'b0;
    end else if (!selActive) begin
      phase     <= PH_CMD;
      bitCnt    <= '0;
      remaining <= '0;
      isRead    <= 1'b0;
    end else begin
      if (fallEdge) bitCnt <= bitCnt + 3'd1;
      if (byteDone) begin
        case (phase)
          PH_CMD: begin
            remaining <= CNT_W'(1) << cmdBurst;
            isRead    <= cmdRead;
            phase     <= PH_DATA;
          end
          PH_DATA: begin
            remaining <= remaining - CNT_W'(1);
            if (remaining == CNT_W'(1)) phase <= PH_DONE;
          end
          default: phase <= PH_DONE;
        endcase
      end
    end
  end

  AST_INC_WITHIN_BURST: assert property (@(posedge clk) disable iff (!rstN)
    st.addrInc |-> remaining != '0); // R3

  AST_BURST_POW2: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && selActive && phase == PH_CMD) |=> ($onehot0(remaining) && remaining != '0)); // R3

  AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DONE && selActive) |=> (phase == PH_DONE || !selActive)); // R6
endmodule

// File: rtl/spi_burst_dp.sv
module spi_burst_dp
  import spi_burst_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic              mosiS,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] rxByte,
  output logic              misoBit
);
  localparam int NREG = 1 << ADDR_W;

  logic [BYTE_W-1:0] regs [NREG];
  logic [BYTE_W-1:0] rxShift, txShift;
  logic [ADDR_W-1:0] addr, addrNext;

  assign rxByte   = {rxShift[BYTE_W-2:0], mosiS};
  assign addrNext = st.addrLoad ? rxByte[ADDR_W:1] : ADDR_W'(addr + 1'b1);
  assign rdData   = regs[rdAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      misoBit <= 1'b0;
      addr    <= '0;
    end else if (st.flush) begin
      rxShift <= '0;
      txShift <= '0;
      misoBit <= 1'b0;
    end else begin
      if (st.shiftRx) rxShift <= rxByte;
      if (st.loadTx)       txShift <= regs[addrNext];
      else if (st.clearTx) txShift <= '0;
      else if (st.shiftTx) begin
        misoBit <= txShift[BYTE_W-1];
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
      end
      if (st.addrLoad || st.addrInc) addr <= addrNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (st.commit) begin
      regs[addr] <= rxByte;
    end
  end

  AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |=> regs[$past(addr)] == $past(rxByte)); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (st.addrInc && !st.addrLoad && !st.flush) |=> addr == ADDR_W'($past(addr) + 1'b1)); // R4
endmodule

// File: rtl/spi_burst_regs.sv
module spi_burst_regs
  import spi_burst_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgSelN,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  output logic              misoOe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0] rdData
);
  logic [2:0]        pinsS;
  logic              selActive;
  logic [BYTE_W-1:0] rxByte;
  strobe_t           st;

  spi_burst_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({cfgSelN, sclk, mosi}),
    .syncOut(pinsS)
  );

  assign selActive = !pinsS[2];

  spi_burst_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .selActive(selActive),
    .sclkS(pinsS[1]),
    .cmdBurst(rxByte[BYTE_W-1:BYTE_W-BURST_W]),
    .cmdRead(rxByte[0]),
    .st(st)
  );

  spi_burst_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN),
    .st(st),
    .mosiS(pinsS[0]),
    .rdAddr(rdAddr),
    .rdData(rdData),
    .rxByte(rxByte),
    .misoBit(miso)
  );

  assign misoOe = selActive;
endmodule

// File: tb/spi_burst_regs_test.sv
module spi_burst_regs_test;
  localparam int HALF = 6;

  logic clk = 0;
  logic rstN = 0;
  logic cfgSelN = 1, sclk = 0, mosi = 0;
  logic miso, misoOe;
  logic [4:0] rdAddr = 0;
  logic [7:0] rdData;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] model [32];

  spi_burst_regs uut (
    .clk(clk), .rstN(rstN), .cfgSelN(cfgSelN), .sclk(sclk), .mosi(mosi),
    .miso(miso), .misoOe(misoOe), .rdAddr(rdAddr), .rdData(rdData)
  );

  always #5 clk = ~clk;

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      sclk = 1; mosi = tx[i];
      waitClk(HALF);
      rx[i] = miso;
      sclk = 0;
      waitClk(HALF);
    end
  endtask

  task automatic selBegin();
    cfgSelN = 0;
    waitClk(HALF);
  endtask

  task automatic selEnd();
    waitClk(HALF);
    cfgSelN = 1;
    waitClk(HALF);
  endtask

  task automatic checkBank(input string req);
    for (int a = 0; a < 32; a++) begin
      rdAddr = 5'(a);
      #1;
      check(rdData === model[a], req, rdData, model[a]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx, d;
    int n;
    for (int a = 0; a < 32; a++) model[a] = 8'h00;
    waitClk(3);
    rstN = 1;
    waitClk(4);
    // R9 reset clears bank, R8 parallel port
    checkBank("R9/R8 reset");
    check(misoOe === 1'b0, "R1 idle release", misoOe, 0);

    // R1 select drives line low
    selBegin();
    check(misoOe === 1'b1 && miso === 1'b0, "R1 selected drive", {misoOe, miso}, 2'b10);
    selEnd();
    check(misoOe === 1'b0, "R1 deselect release", misoOe, 0);

    // R3 R4 R6 write sweep
    for (int code = 0; code < 4; code++) begin
      for (int start = 0; start < 32; start += 3) begin
        n = 1 << code;
        selBegin();
        xfer({2'(code), 5'(start), 1'b0}, 8, rx);
        for (int k = 0; k < n + 1; k++) begin
          d = 8'((start * 7 + k * 29 + code * 53 + 1) & 255);
          xfer(d, 8, rx);
          if (k < n) model[(start + k) % 32] = d;
        end
        selEnd();
        checkBank("R4/R3/R6 write burst");
      end
    end

    // R5 R2 R6 read sweep
    for (int code = 0; code < 4; code++) begin
      for (int start = 1; start < 32; start += 5) begin
        n = 1 << code;
        selBegin();
        xfer({2'(code), 5'(start), 1'b1}, 8, rx);
        for (int k = 0; k < n + 2; k++) begin
          xfer(8'hA5, 8, rx);
          if (k < n) check(rx === model[(start + k) % 32], "R5/R2 read data", rx, model[(start + k) % 32]);
          else       check(rx === 8'h00, "R6 read past burst", rx, 0);
        end
        selEnd();
      end
    end
    // R2 reads changed nothing
    checkBank("R2 read no write");

    // R7 abort in single-byte burst
    selBegin();
    xfer({2'b00, 5'd9, 1'b0}, 8, rx);
    xfer(8'h3C, 5, rx);
    selEnd();
    checkBank("R7 abort partial byte");

    // R7 abort second byte of 2-byte burst
    selBegin();
    xfer({2'b01, 5'd20, 1'b0}, 8, rx);
    xfer(8'h11, 8, rx);
    model[20] = 8'h11;
    xfer(8'hEE, 4, rx);
    selEnd();
    checkBank("R7 abort keeps earlier byte");

    // R7 abort during command, then next transaction works
    selBegin();
    xfer({2'b00, 5'd3, 1'b0}, 6, rx);
    selEnd();
    selBegin();
    xfer({2'b00, 5'd3, 1'b0}, 8, rx);
    xfer(8'h5A, 8, rx);
    model[3] = 8'h5A;
    selEnd();
    checkBank("R7/R2 recover after command abort");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule